// File: doc/BRIEF.md
# Rotated Framebuffer Scan Parameter Calculator

This block turns a description of a framebuffer into the six numbers a two-dimensional DMA engine needs to read the image in display order. The description covers a base address, the visible width and height in pixels, an optional virtual line width, optional horizontal and vertical scale factors, a pixel size code, a rotation in degrees and a mirror flag. The six numbers are the first address read, the last address read, the element count per frame, the frame count, a signed element index and a signed frame index.

Pixel (x, y) lives at `base + (y * vw * ys + x * xs) * es`. Here vw is the effective line width, xs and ys are the scale factors and es is the element size in bytes. An index is the byte distance from one pixel to the next pixel in scan order, less es, plus one. The block picks the start corner, the end corner and the two scan directions for each of the eight rotation and mirror cases.

A one-cycle `start` pulse latches the result. `done` rises on the next cycle. When an input is illegal, `err` is raised together with `done` and the parameter outputs keep their previous values. An input flag selects a legacy address convention for the end address.

Top module: `fb_scan_calc`

## Requirements
- R1: After reset every output is zero. `done` is high for exactly the one cycle that follows each cycle in which `start` was high.
- R2: Pixel size code `pix_fmt` 0 selects 1 byte, 1 selects 2 bytes and 2 selects 4 bytes. Code 3 raises `err`.
- R3: A `line_pix` of zero uses the visible width as the line width. A zero `scale_x` or `scale_y` acts as a scale of 1.
- R4: A nonzero `line_pix` below `vis_w` raises `err`.
- R5: A `rot_deg` value other than 0, 90, 180 or 270 raises `err`.
- R6: When `err` is raised, the address, count and index outputs hold the values they had before that `start`.
- R7: At 0 and 180 degrees, `elem_cnt` equals the width and `frame_cnt` equals the height. At 90 and 270 degrees the two are swapped.
- R8: `first_addr` and `last_addr` are opposite corners of the image. The corners are (0,0)/(w-1,h-1) at 0 degrees and (0,h-1)/(w-1,0) at 90 degrees. They are (w-1,h-1)/(0,0) at 180 degrees and (w-1,0)/(0,h-1) at 270 degrees. Mirroring swaps the x coordinate of both corners.
- R9: `elem_idx` (16-bit two's complement) is the scan step from one element to the next. At 0 degrees it is one pixel right, and at 180 degrees one pixel left. At 90 degrees it is one row up, and at 270 degrees one row down. Mirroring reverses the horizontal steps.
- R10: `frame_idx` (32-bit two's complement) is the step from the last element of one frame to the first element of the next, computed from the corners and directions of R8 and R9.
- R11: With `legacy` high, rotation 0, no mirror and 4-byte pixels, `last_addr` is two more than the last pixel address. In every other case `legacy` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Latch a new computation |
| fb_base | input | 32 | Framebuffer base address |
| vis_w | input | 16 | Visible width in pixels |
| vis_h | input | 16 | Visible height in pixels |
| line_pix | input | 16 | Virtual line width, 0 means vis_w |
| scale_x | input | 8 | Horizontal scale, 0 means 1 |
| scale_y | input | 8 | Vertical scale, 0 means 1 |
| pix_fmt | input | 2 | Pixel size code |
| rot_deg | input | 9 | Rotation in degrees |
| mirror | input | 1 | Horizontal mirror |
| legacy | input | 1 | Legacy end-address convention |
| done | output | 1 | Result ready (one cycle) |
| err | output | 1 | Inputs were illegal |
| first_addr | output | 32 | First address scanned |
| last_addr | output | 32 | Last address scanned |
| elem_cnt | output | 16 | Elements per frame |
| frame_cnt | output | 16 | Frames per block |
| elem_idx | output | 16 | Signed element index |
| frame_idx | output | 32 | Signed frame index |

## Verification
The assertions assume that the inputs are steady during the cycle `start` is high and that the visible width and height are nonzero. They do not assume that inputs stay steady after that cycle. The bench changes inputs only on falling edges and holds them until the next computation. It sweeps only small nonzero dimensions across every rotation, mirror setting and legal pixel size. It applies the three illegal-input cases on their own, so that the values held under R6 can be compared against the last good run.

// File: rtl/fb_scan_calc.sv
module fb_scan_calc #(
  parameter int AW   = 32,
  parameter int DIMW = 16,
  parameter int SCW  = 8,
  parameter int EIW  = 16,
  parameter int FIW  = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [AW-1:0]         fb_base,
  input  logic [DIMW-1:0]       vis_w,
  input  logic [DIMW-1:0]       vis_h,
  input  logic [DIMW-1:0]       line_pix,
  input  logic [SCW-1:0]        scale_x,
  input  logic [SCW-1:0]        scale_y,
  input  logic [1:0]            pix_fmt,
  input  logic [8:0]            rot_deg,
  input  logic                  mirror,
  input  logic                  legacy,
  output logic                  done,
  output logic                  err,
  output logic [AW-1:0]         first_addr,
  output logic [AW-1:0]         last_addr,
  output logic [DIMW-1:0]       elem_cnt,
  output logic [DIMW-1:0]       frame_cnt,
  output logic signed [EIW-1:0] elem_idx,
  output logic signed [FIW-1:0] frame_idx
);
  localparam int MW = AW + 2*DIMW + SCW;
  localparam logic signed [MW-1:0] ONE = MW'(1);

  logic [2:0] es;
  logic [DIMW-1:0] vw;
  logic [SCW-1:0] xs, ys;
  logic [1:0] rsel;
  logic rot_bad, fmt_bad, vw_bad, bad, odd;
  logic signed [MW-1:0] cs, rs, xm, ym;
  logic signed [MW-1:0] tx, ty, bx, by, eic, eir, fic, fir;
  logic signed [MW-1:0] top_off, bot_off, ei_v, fi_v;
  logic [AW-1:0] top_n, bot_n;

  assign es = (pix_fmt == 2'd0) ? 3'd1 : (pix_fmt == 2'd1) ? 3'd2 : 3'd4;
  assign fmt_bad = (pix_fmt == 2'd3);
  assign vw = (line_pix == '0) ? vis_w : line_pix;
  assign vw_bad = (line_pix != '0) && (line_pix < vis_w);
  assign xs = (scale_x == '0) ? SCW'(1) : scale_x;
  assign ys = (scale_y == '0) ? SCW'(1) : scale_y;
  assign cs = MW'(xs) * MW'(es);
  assign rs = MW'(vw) * MW'(ys) * MW'(es);
  assign xm = MW'(vis_w) - ONE;
  assign ym = MW'(vis_h) - ONE;

  always_comb begin
    rot_bad = 1'b0;
    rsel = 2'd0;
    case (rot_deg)
      9'd0:   rsel = 2'd0;
      9'd90:  rsel = 2'd1;
      9'd180: rsel = 2'd2;
      9'd270: rsel = 2'd3;
      default: rot_bad = 1'b1;
    endcase
  end

  assign odd = rsel[0];
  assign bad = rot_bad | fmt_bad | vw_bad;

  always_comb begin
    tx = '0; ty = '0; bx = '0; by = '0;
    eic = '0; eir = '0; fic = '0; fir = '0;
    case ({rsel, mirror})
      3'b000: begin bx = xm; by = ym; eic = ONE;  fic = -xm; fir = ONE; end
      3'b001: begin tx = xm; by = ym; eic = -ONE; fic = xm;  fir = ONE; end
      3'b010: begin ty = ym; bx = xm; eir = -ONE; fic = ONE; fir = ym; end
      3'b011: begin tx = xm; ty = ym; eir = -ONE; fic = -ONE; fir = ym; end
      3'b100: begin tx = xm; ty = ym; eic = -ONE; fic = xm;  fir = -ONE; end
      3'b101: begin ty = ym; bx = xm; eic = ONE;  fic = -xm; fir = -ONE; end
      3'b110: begin tx = xm; by = ym; eir = ONE;  fic = -ONE; fir = -ym; end
      default: begin bx = xm; by = ym; eir = ONE; fic = ONE; fir = -ym; end
    endcase
  end

  assign top_off = tx * cs + ty * rs;
  assign bot_off = bx * cs + by * rs;
  assign ei_v = eic * cs + eir * rs - MW'(es) + ONE;
  assign fi_v = fic * cs + fir * rs - MW'(es) + ONE;
  assign top_n = fb_base + top_off[AW-1:0];
  assign bot_n = fb_base + bot_off[AW-1:0] +
                 ((legacy && rsel == 2'd0 && !mirror && pix_fmt == 2'd2) ? AW'(2) : AW'(0));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done <= 1'b0;
      err <= 1'b0;
      first_addr <= '0;
      last_addr <= '0;
      elem_cnt <= '0;
      frame_cnt <= '0;
      elem_idx <= '0;
      frame_idx <= '0;
    end else begin
      done <= start;
      err <= start & bad;
      if (start && !bad) begin
        first_addr <= top_n;
        last_addr <= bot_n;
        elem_cnt <= odd ? vis_h : vis_w;
        frame_cnt <= odd ? vis_w : vis_h;
        elem_idx <= ei_v[EIW-1:0];
        frame_idx <= fi_v[FIW-1:0];
      end
    end
  end

  // R1
  done_follows_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> done);
  // R1
  done_needs_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> !done);
  // R4
  short_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && line_pix != '0 && line_pix < vis_w) |=> err);
  // R5
  rot_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && rot_deg != 9'd0 && rot_deg != 9'd90 && rot_deg != 9'd180 && rot_deg != 9'd270) |=> err);
  // R6
  hold_on_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> ($stable(first_addr) && $stable(last_addr) && $stable(frame_idx) && $stable(elem_cnt)));
  // R7
  count_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && (rot_deg == 9'd90 || rot_deg == 9'd270) && !fmt_bad && !vw_bad)
      |=> (elem_cnt == $past(vis_h) && frame_cnt == $past(vis_w)));
endmodule

// File: tb/fb_scan_calc_test.sv
module fb_scan_calc_test;
  localparam int CLK_P = 10;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [31:0] fb_base = '0;
  logic [15:0] vis_w = '0, vis_h = '0, line_pix = '0;
  logic [7:0] scale_x = '0, scale_y = '0;
  logic [1:0] pix_fmt = '0;
  logic [8:0] rot_deg = '0;
  logic mirror = 1'b0, legacy = 1'b0;
  logic done, err;
  logic [31:0] first_addr, last_addr;
  logic [15:0] elem_cnt, frame_cnt;
  logic signed [15:0] elem_idx;
  logic signed [31:0] frame_idx;

  int checks = 0, errors = 0;
  longint m_base, m_vw, m_xs, m_ys, m_es;

  fb_scan_calc uut (.clk(clk), .rst_n(rst_n), .start(start), .fb_base(fb_base),
    .vis_w(vis_w), .vis_h(vis_h), .line_pix(line_pix), .scale_x(scale_x),
    .scale_y(scale_y), .pix_fmt(pix_fmt), .rot_deg(rot_deg), .mirror(mirror),
    .legacy(legacy), .done(done), .err(err), .first_addr(first_addr),
    .last_addr(last_addr), .elem_cnt(elem_cnt), .frame_cnt(frame_cnt),
    .elem_idx(elem_idx), .frame_idx(frame_idx));

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [31:0] pa(longint x, longint y);
    longint v = m_base + (y * m_vw * m_ys + x * m_xs) * m_es;
    return v[31:0];
  endfunction

  function automatic logic [31:0] stp(longint sx, longint sy, longint dx, longint dy);
    logic [31:0] d = pa(dx, dy) - pa(sx, sy) - 32'(m_es) + 32'd1;
    return d;
  endfunction

  task automatic fire(logic [31:0] b, int w, int h, int vw, int xs, int ys,
                      int fmt, int rot, bit mir, bit leg);
    @(negedge clk);
    fb_base = b; vis_w = 16'(w); vis_h = 16'(h); line_pix = 16'(vw);
    scale_x = 8'(xs); scale_y = 8'(ys); pix_fmt = 2'(fmt); rot_deg = 9'(rot);
    mirror = mir; legacy = leg; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic good(logic [31:0] b, int w, int h, int vw, int xs, int ys,
                      int fmt, int rot, bit mir, bit leg);
    longint xm = w - 1, ym = h - 1;
    logic [31:0] et, eb, ee, ef;
    int ec, fc;
    m_base = b; m_vw = (vw == 0) ? w : vw;   // R3
    m_xs = (xs == 0) ? 1 : xs; m_ys = (ys == 0) ? 1 : ys;
    m_es = (fmt == 0) ? 1 : (fmt == 1) ? 2 : 4;   // R2
    case ({rot, 1'b0} | mir)
      0:   begin et = pa(0,0);   eb = pa(xm,ym); ee = stp(0,0,1,0); ef = stp(xm,0,0,1); end
      1:   begin et = pa(xm,0);  eb = pa(0,ym);  ee = stp(1,0,0,0); ef = stp(0,0,xm,1); end
      180: begin et = pa(0,ym);  eb = pa(xm,0);  ee = stp(0,1,0,0); ef = stp(0,0,1,ym); end
      181: begin et = pa(xm,ym); eb = pa(0,0);   ee = stp(0,1,0,0); ef = stp(1,0,0,ym); end
      360: begin et = pa(xm,ym); eb = pa(0,0);   ee = stp(1,0,0,0); ef = stp(0,1,xm,0); end
      361: begin et = pa(0,ym);  eb = pa(xm,0);  ee = stp(0,0,1,0); ef = stp(xm,1,0,0); end
      540: begin et = pa(xm,0);  eb = pa(0,ym);  ee = stp(0,0,0,1); ef = stp(1,ym,0,0); end
      default: begin et = pa(0,0); eb = pa(xm,ym); ee = stp(0,0,0,1); ef = stp(0,ym,1,0); end
    endcase
    if (leg && rot == 0 && !mir && fmt == 2) eb = eb + 32'd2;   // R11
    ec = (rot == 90 || rot == 270) ? h : w;
    fc = (rot == 90 || rot == 270) ? w : h;
    fire(b, w, h, vw, xs, ys, fmt, rot, mir, leg);
    chk("R1 done", done, 1);
    chk("R2 err", err, 0);
    chk("R8 first", first_addr, et);
    chk(leg ? "R11 last" : "R8 last", last_addr, eb);
    chk("R7 elem_cnt", elem_cnt, ec);
    chk("R7 frame_cnt", frame_cnt, fc);
    chk("R9 elem_idx", elem_idx, longint'($signed(ee[15:0])));
    chk("R10 frame_idx", frame_idx, longint'($signed(ef)));
    @(negedge clk);
    chk("R1 done drop", done, 0);
  endtask

  task automatic bad(string req, int w, int vw, int fmt, int rot);
    logic [31:0] pf = first_addr, pl = last_addr, pfi = frame_idx;
    logic [15:0] pe = elem_idx, pc = elem_cnt;
    fire(32'h7777_0000, w, 3, vw, 2, 2, fmt, rot, 1'b1, 1'b0);
    chk({req, " err"}, err, 1);
    chk({req, " done"}, done, 1);
    chk("R6 first hold", first_addr, pf);
    chk("R6 last hold", last_addr, pl);
    chk("R6 fidx hold", frame_idx, pfi);
    chk("R6 eidx hold", elem_idx, pe);
    chk("R6 cnt hold", elem_cnt, pc);
  endtask

  initial begin
    repeat (CLK_P * 20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 reset done", done, 0);
    chk("R1 reset err", err, 0);
    chk("R1 reset first", first_addr, 0);
    chk("R1 reset fidx", frame_idx, 0);
    rst_n = 1'b1;
    for (int cfg = 0; cfg < 4; cfg++) begin
      for (int fmt = 0; fmt < 3; fmt++) begin
        for (int r = 0; r < 4; r++) begin
          for (int m = 0; m < 2; m++) begin
            case (cfg)
              0: good(32'h1000_0000, 4, 3, 0, 0, 0, fmt, r * 90, m[0], 1'b0);
              1: good(32'h2000_0040, 5, 2, 9, 2, 3, fmt, r * 90, m[0], 1'b0);
              2: good(32'h0000_0010, 1, 1, 0, 1, 0, fmt, r * 90, m[0], 1'b1);
              default: good(32'hFFFF_FF00, 7, 6, 8, 0, 2, fmt, r * 90, m[0], 1'b1);
            endcase
          end
        end
      end
    end
    // R3 explicit: zero line width equals visible width given as line width
    good(32'h3000_0000, 6, 4, 6, 1, 1, 1, 90, 1'b0, 1'b0);
    good(32'h3000_0000, 6, 4, 0, 0, 0, 1, 90, 1'b0, 1'b0);
    // R11 legacy only in one case
    good(32'h4000_0000, 3, 3, 0, 0, 0, 2, 0, 1'b0, 1'b1);
    good(32'h4000_0000, 3, 3, 0, 0, 0, 1, 0, 1'b0, 1'b1);
    bad("R2", 4, 0, 3, 0);
    bad("R4", 5, 4, 1, 90);
    bad("R5", 4, 0, 0, 45);
    bad("R5", 4, 0, 2, 360);
    good(32'h5000_0000, 2, 2, 0, 0, 0, 0, 270, 1'b1, 1'b0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule